// File: doc/BRIEF.md
# Serial Link Frame Assembler

This block turns a stream of payload words into scrambled serial-link frames ready for a line encoder. For every accepted word it lays out a frame: the payload in the low bits, one forward control-channel bit above them, and an even-parity bit on top. It then XORs the frame with an additive keystream from a 16-bit LFSR. Two frame widths are supported. A wide frame is 32 bits, with 30 payload bits. A narrow frame is 24 bits, with 22 payload bits. The width is picked per word.

The upstream side offers words with a valid/ready handshake. The downstream encoder takes one registered frame word per cycle under its own ready. A link-start pulse reseeds the scrambler so the far end can lock its descrambler to a known state. The keystream runs on across frames and advances only when a word is accepted.

Top module: `link_frame_asm`

## Requirements
- R1: After reset, `enc_valid` is 0 and `src_ready` is 1.
- R2: In wide mode (`wide_mode`=1), the pre-scramble frame has payload bits 29:0 at frame bits 29:0, the control bit at bit 30 and parity at bit 31.
- R3: In narrow mode (`wide_mode`=0), the pre-scramble frame has payload bits 21:0 at bits 21:0, the control bit at bit 22 and parity at bit 23. Payload bits 29:22 are ignored, and `enc_word` bits 31:24 are 0.
- R4: The parity bit makes the count of ones over all frame bits of the selected width even, before scrambling.
- R5: When `cc_pending` is 0, the control bit is 1 whatever the value of `cc_data`. When `cc_pending` is 1, it equals `cc_data`.
- R6: The scrambler uses a Fibonacci LFSR s[15:0] with seed 0xFFFF. Keystream bit k is s[15] at step k. Each step shifts s left and inserts s[15]^s[4]^s[3]^s[2]. Frame bit k is XORed with keystream bit k. One frame consumes 24 or 32 steps, according to its width, and the LFSR state carries over to the next frame.
- R7: While `link_start` is 1, the LFSR is loaded with the seed. A word accepted in that same cycle is scrambled starting from the seed.
- R8: A word is accepted when `src_valid` and `src_ready` are both 1. It appears on `enc_word` with `enc_valid`=1 on the next cycle. `src_ready` is 1 exactly when `enc_valid` is 0 or `enc_ready` is 1. While `enc_valid`=1 and `enc_ready`=0, the output word and `enc_wide` hold steady.
- R9: Cycles with no accepted word do not advance the LFSR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| link_start | input | 1 | Reseeds the scrambler |
| src_valid | input | 1 | Payload word offered |
| src_ready | output | 1 | Block can take a word |
| payload | input | 30 | Payload bits; only 21:0 used in narrow mode |
| wide_mode | input | 1 | 1 = 32-bit frame, 0 = 24-bit frame |
| cc_pending | input | 1 | A control-channel bit is waiting |
| cc_data | input | 1 | Control-channel bit value |
| enc_valid | output | 1 | Frame word available to encoder |
| enc_ready | input | 1 | Encoder takes the word |
| enc_word | output | 32 | Scrambled frame word |
| enc_wide | output | 1 | Width of the frame in `enc_word` |

## Verification
Payloads of all zeros expose the bare keystream together with the control and parity bits. All-ones and alternating payloads reveal bit placement and parity errors. Narrow frames carry junk in payload bits 29:22, so any leak of those bits into the frame shows up. Mixing widths back to back separates a correct 24/32-step advance from a fixed one, and idle gaps show whether the LFSR moves without traffic. Link-start pulses, both alone and together with a word, check the reseed, and a stalling encoder ready checks that the held output stays put.

// File: rtl/link_frame_pkg.sv
package link_frame_pkg;
  localparam int unsigned WIDE_W    = 32;
  localparam int unsigned NARROW_W  = 24;
  localparam int unsigned CTRL_BITS = 2;
  localparam int unsigned PAY_W     = WIDE_W - CTRL_BITS;
  localparam int unsigned LFSR_W    = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hFFFF;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'h001C;

  typedef struct packed {
    logic              wide;
    logic [WIDE_W-1:0] word;
  } frame_t;
endpackage

// File: rtl/lf_frame_builder.sv
module lf_frame_builder
  import link_frame_pkg::*;
#(
  parameter int unsigned W_WIDE   = WIDE_W,
  parameter int unsigned W_NARROW = NARROW_W,
  localparam int unsigned PW      = W_WIDE - 2,
  localparam int unsigned NPW     = W_NARROW - 2
) (
  input  logic [PW-1:0]     payload,
  input  logic              wide_mode,
  input  logic              cc_pending,
  input  logic              cc_data,
  output logic [W_WIDE-1:0] frame
);
  logic cc_sel;
  logic par_wide, par_narrow;

  assign cc_sel = cc_pending ? cc_data : 1'b1;

  always_comb begin
    par_wide   = ^{cc_sel, payload};
    par_narrow = ^{cc_sel, payload[NPW-1:0]};
    frame      = '0;
    if (wide_mode) begin
      frame[PW-1:0]   = payload;
      frame[W_WIDE-2] = cc_sel;
      frame[W_WIDE-1] = par_wide;
    end else begin
      frame[NPW-1:0]    = payload[NPW-1:0];
      frame[W_NARROW-2] = cc_sel;
      frame[W_NARROW-1] = par_narrow;
    end
  end
endmodule

// File: rtl/lf_scrambler.sv
module lf_scrambler
  import link_frame_pkg::*;
#(
  parameter int unsigned W_WIDE        = WIDE_W,
  parameter int unsigned W_NARROW      = NARROW_W,
  parameter int unsigned SW            = LFSR_W,
  parameter logic [SW-1:0] SEED        = LFSR_SEED,
  parameter logic [SW-1:0] TAPS        = LFSR_TAPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reseed,
  input  logic              advance,
  input  logic              wide_mode,
  output logic [W_WIDE-1:0] keystream
);
  logic [SW-1:0] state_q, state_d, start_st;
  logic [SW-1:0] chain [W_WIDE+1];

  assign start_st = reseed ? SEED : state_q;
  assign chain[0] = start_st;

  genvar gi;
  generate
    for (gi = 0; gi < W_WIDE; gi++) begin : g_step
      assign keystream[gi] = chain[gi][SW-1];
      assign chain[gi+1]   = {chain[gi][SW-2:0],
                              chain[gi][SW-1] ^ (^(chain[gi] & TAPS))};
    end
  endgenerate

  always_comb begin
    state_d = start_st;
    if (advance) state_d = wide_mode ? chain[W_WIDE] : chain[W_NARROW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reseed && !advance) |=> $stable(state_q));
  // R7
  reseed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reseed && !advance) |=> (state_q == SEED));
endmodule

// File: rtl/lf_out_stage.sv
module lf_out_stage
  import link_frame_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   in_valid,
  output logic   in_ready,
  input  frame_t in_frame,
  output logic   out_valid,
  input  logic   out_ready,
  output frame_t out_frame
);
  logic   valid_q, valid_d, load;
  frame_t frame_q;

  assign in_ready = !valid_q || out_ready;
  assign load     = in_valid && in_ready;

  always_comb begin
    valid_d = valid_q;
    if (load)           valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load) frame_q <= in_frame;
  end

  assign out_valid = valid_q;
  assign out_frame = frame_q;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_frame)));
  // R8
  accept_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid);
  // R8
  drain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

// File: rtl/link_frame_asm.sv
module link_frame_asm
  import link_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_start,
  input  logic              src_valid,
  output logic              src_ready,
  input  logic [PAY_W-1:0]  payload,
  input  logic              wide_mode,
  input  logic              cc_pending,
  input  logic              cc_data,
  output logic              enc_valid,
  input  logic              enc_ready,
  output logic [WIDE_W-1:0] enc_word,
  output logic              enc_wide
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [WIDE_W-1:0] frame, keystream, ks_mask;
  logic              accept;
  frame_t            stage_in, stage_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  lf_frame_builder u_build (
    .payload    (payload),
    .wide_mode  (wide_mode),
    .cc_pending (cc_pending),
    .cc_data    (cc_data),
    .frame      (frame)
  );

  assign accept = src_valid && src_ready;

  lf_scrambler u_scr (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .reseed    (link_start),
    .advance   (accept),
    .wide_mode (wide_mode),
    .keystream (keystream)
  );

  assign ks_mask       = wide_mode ? '1 : {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  assign stage_in.word = frame ^ (keystream & ks_mask);
  assign stage_in.wide = wide_mode;

  lf_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_valid  (src_valid),
    .in_ready  (src_ready),
    .in_frame  (stage_in),
    .out_valid (enc_valid),
    .out_ready (enc_ready),
    .out_frame (stage_out)
  );

  assign enc_word = stage_out.word;
  assign enc_wide = stage_out.wide;

  // R3
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (enc_valid && !enc_wide) |-> (enc_word[WIDE_W-1:NARROW_W] == '0));
endmodule

// File: tb/test_link_frame_asm.sv
module test_link_frame_asm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_start = 1'b0;
  logic        src_valid = 1'b0;
  logic        src_ready;
  logic [29:0] payload = '0;
  logic        wide_mode = 1'b1;
  logic        cc_pending = 1'b0;
  logic        cc_data = 1'b0;
  logic        enc_valid;
  logic        enc_ready = 1'b1;
  logic [31:0] enc_word;
  logic        enc_wide;

  typedef struct {
    logic [31:0] word;
    logic        wide;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  logic [15:0] m_lfsr = 16'hFFFF;
  logic        bp_on = 1'b0;
  int          cyc = 0;
  logic        held_flag = 1'b0;
  logic [31:0] held_word;
  bit          done = 0;

  always #5 clk = ~clk;

  link_frame_asm i_link_frame_asm (
    .clk(clk), .rst_n(rst_n), .link_start(link_start),
    .src_valid(src_valid), .src_ready(src_ready), .payload(payload),
    .wide_mode(wide_mode), .cc_pending(cc_pending), .cc_data(cc_data),
    .enc_valid(enc_valid), .enc_ready(enc_ready), .enc_word(enc_word),
    .enc_wide(enc_wide)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model built from R2..R7: layout, parity, idle control bit, additive keystream.
  task automatic model_push(input logic [29:0] p, input logic w, input logic cp,
                            input logic cb, input logic ls, input string tag);
    int          nb;
    logic [31:0] f;
    logic        c, ks, fb;
    exp_t        e;
    nb = w ? 32 : 24;
    c  = cp ? cb : 1'b1;
    f  = '0;
    for (int k = 0; k < nb - 2; k++) f[k] = p[k];
    f[nb-2] = c;
    f[nb-1] = 1'b0;
    f[nb-1] = ^f;
    if (ls) m_lfsr = 16'hFFFF;
    for (int k = 0; k < nb; k++) begin
      ks     = m_lfsr[15];
      fb     = m_lfsr[15] ^ m_lfsr[4] ^ m_lfsr[3] ^ m_lfsr[2];
      m_lfsr = {m_lfsr[14:0], fb};
      f[k]   = f[k] ^ ks;
    end
    e.word = f; e.wide = w; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic send(input logic [29:0] p, input logic w, input logic cp,
                      input logic cb, input logic ls, input string tag);
    @(posedge clk); #1;
    payload = p; wide_mode = w; cc_pending = cp; cc_data = cb;
    link_start = ls; src_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (src_ready) begin
        model_push(p, w, cp, cb, ls, tag);
        break;
      end
    end
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    src_valid = 1'b0; link_start = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic pulse_start();
    @(posedge clk); #1;
    src_valid = 1'b0; link_start = 1'b1;
    @(negedge clk); m_lfsr = 16'hFFFF;
    @(posedge clk); #1; link_start = 1'b0;
  endtask

  initial forever begin
    @(posedge clk); #2;
    cyc++;
    enc_ready = bp_on ? ((cyc % 3) != 0) : 1'b1;
  end

  // Monitor: pops the scoreboard on every transfer, checks stall behaviour.
  always @(negedge clk) begin
    if (rst_n && held_flag) begin
      check(enc_valid && enc_word == held_word, "R8 hold", enc_word, held_word);
      held_flag = 1'b0;
    end
    if (rst_n && enc_valid && !enc_ready) begin
      check(src_ready == 1'b0, "R8 ready", {31'b0, src_ready}, 32'h0);
      held_word = enc_word;
      held_flag = 1'b1;
    end
    if (rst_n && enc_valid && enc_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8 extra word", enc_word, 32'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(enc_word == e.word && enc_wide == e.wide, e.tag,
              enc_word, e.word);
      end
    end
  end

  initial begin
    int wd = 0;
    while (!done && wd < 20000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=<20000 cycles", wd);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check(enc_valid == 1'b0, "R1 valid", {31'b0, enc_valid}, 32'h0);
    check(src_ready == 1'b1, "R1 ready", {31'b0, src_ready}, 32'h1);

    // R2 R4 R5 R6: wide frames, zero/ones/alternating payloads, control bit choices
    send(30'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b0, "R2 R6 zero wide idle cc");
    send(30'h3FFF_FFFF, 1'b1, 1'b1, 1'b0, 1'b0, "R2 R4 ones wide cc0");
    send(30'h1555_5555, 1'b1, 1'b1, 1'b1, 1'b0, "R2 R4 alt wide cc1");
    send(30'h2AAA_AAAA, 1'b1, 1'b0, 1'b0, 1'b0, "R5 cc_data ignored");
    // R3: junk in bits 29:22 must not leak
    send(30'h3FC0_0000, 1'b0, 1'b0, 1'b0, 1'b0, "R3 narrow junk upper");
    send(30'h3FFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b0, "R3 R4 narrow ones cc0");
    send(30'h2A15_5555, 1'b0, 1'b1, 1'b1, 1'b0, "R3 narrow alt cc1");
    // R6: alternating widths back to back
    for (int i = 0; i < 8; i++)
      send(30'(32'h0123_4567 * (i + 3)), i[0], i[1], i[2], 1'b0, "R6 mixed widths");
    // R9: gaps between frames
    idle(5);
    send(30'h0000_00FF, 1'b1, 1'b1, 1'b1, 1'b0, "R9 after gap");
    idle(3);
    send(30'h0000_00FF, 1'b0, 1'b0, 1'b0, 1'b0, "R9 after gap narrow");
    // R7: reseed alone and with a frame
    idle(2);
    pulse_start();
    send(30'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b0, "R7 after reseed");
    send(30'h0000_1234, 1'b0, 1'b1, 1'b0, 1'b0, "R7 before reseed frame");
    send(30'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b1, "R7 reseed with frame");
    // R8: encoder backpressure
    idle(2);
    bp_on = 1'b1;
    for (int i = 0; i < 12; i++)
      send(30'(32'h1357_9BDF ^ (i * 32'h0101_0101)), (i % 3) != 0, 1'b1, i[0], 1'b0, "R8 R6 backpressure");
    idle(10);
    bp_on = 1'b0;
    idle(5);
    check(sb.size() == 0, "R8 all delivered", 32'(sb.size()), 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule